// File: doc/BRIEF.md
# Dual Prescaled Timer Unit

This block holds two independent down-counting timers behind one small register bus: a general-purpose timer and a real-time clock. Each timer has a programmable counter reload value, a programmable prescaler reload value, and a four-bit control field. Both fields live in one shared control word. When a timer is enabled, its prescaler counts down on every clock. Each time the prescaler wraps, the main counter steps down once. When the main counter steps past zero, the timer raises a one-cycle interrupt pulse. It then either reloads the counter or stops, depending on its mode bit.

Software first writes the reload values, then writes the control word. The control word sets the persistent mode bits (reload-or-stop and enable) and fires the one-shot load strobes that copy the reload values into the running counter and prescaler. Reading a counter or scaler address returns the live running value, not the programmed one. The general-purpose interrupt feeds interrupt source 12 of the system and the real-time clock feeds source 13; prioritising these sources is left to the interrupt controller.

Top module: `dual_prescaled_timer`

## Requirements
- R1: After reset, every readable register returns 0 and both interrupt outputs are low.
- R2: A write to a counter or scaler address changes only the programmed value. The live value changes on a load strobe in the control word. The strobe bits read back as 0 and the mode bits read back as written.
- R3: Address map: real-time clock counter 0x80, real-time clock scaler 0x84, general-purpose counter 0x88, general-purpose scaler 0x8C, shared control 0x98. Any other address reads 0.
- R3 (continued): The general-purpose field sits in control bits 3:0 and the real-time clock field in bits 11:8, with the same layout: bit 0 = reload at zero (1) or stop at zero (0), bit 1 = load counter strobe, bit 2 = count enable, bit 3 = load scaler strobe.
- R4: While enabled, the prescaler decrements every clock. When it is at zero, it reloads the programmed scaler value and the counter steps down once. With scaler value S, the counter therefore steps every S+1 cycles.
- R5: When the counter is at zero and a prescaler wrap occurs, the timer's interrupt output is high for exactly the following cycle. In reload mode the counter then holds the programmed counter value.
- R6: In stop mode an underflow clears the enable bit (control readback shows it 0). The counter stays at 0 and no further pulses occur.
- R7: While a timer's enable bit is 0, its live counter and prescaler do not change, except through load strobes.
- R8: A load strobe takes priority over a decrement or wrap in the same cycle. The live value equals the programmed value afterwards.
- R9: The real-time clock scaler is 10 bits wide and the general-purpose scaler is 16 bits wide; higher write bits are dropped. Both counters are 32 bits wide.
- R10: The general-purpose timer drives only `irq_gpt` (source 12) and the real-time clock drives only `irq_rtc` (source 13). Either timer's field leaves the other timer untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with clk |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 8 | Byte address of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_gpt | output | 1 | One-cycle underflow pulse of the general-purpose timer |
| irq_rtc | output | 1 | One-cycle underflow pulse of the real-time clock |

## Verification
A corrupted prescaler or counter appears on the live readback of the affected address at the next sample. A wrong wrap decision shifts the counter step off its S+1 cadence within one prescaler period. A wrong underflow or mode decision shows on the interrupt pin and on the control readback in the cycle right after the counter leaves zero. A stuck or misrouted strobe appears in the readback right after the control write, because a loaded value must equal the programmed one.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  // Register byte offsets
  localparam logic [7:0] OFS_RTC_CNT = 8'h80;
  localparam logic [7:0] OFS_RTC_SCL = 8'h84;
  localparam logic [7:0] OFS_GPT_CNT = 8'h88;
  localparam logic [7:0] OFS_GPT_SCL = 8'h8C;
  localparam logic [7:0] OFS_CTRL    = 8'h98;

  // Field placement inside the shared control word
  localparam int FLD_W       = 4;
  localparam int GPT_FLD_LSB = 0;
  localparam int RTC_FLD_LSB = 8;

  // Bit meaning inside one field
  localparam int BIT_RELOAD = 0;
  localparam int BIT_LDCNT  = 1;
  localparam int BIT_ENABLE = 2;
  localparam int BIT_LDSCL  = 3;
endpackage

// File: rtl/dpt_prescaler.sv
module dpt_prescaler #(
  parameter int SCL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [SCL_W-1:0] reload_val,
  output logic [SCL_W-1:0] presc_q,
  output logic             wrap
);
  logic [SCL_W-1:0] presc_d;
  logic             at_zero;

  assign at_zero = (presc_q == '0);
  // a load in the same cycle suppresses the wrap
  assign wrap    = run & at_zero & ~load;

  always_comb begin
    presc_d = presc_q;
    if (load)
      presc_d = reload_val;
    else if (run)
      presc_d = at_zero ? reload_val : presc_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end
endmodule

// File: rtl/dpt_counter.sv
module dpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic             reload_mode,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             underflow
);
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  assign at_zero   = (cnt_q == '0);
  assign underflow = step & at_zero & ~load;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = reload_val;
    else if (step) begin
      if (at_zero) cnt_d = reload_mode ? reload_val : '0;
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dpt_channel.sv
module dpt_channel
  import dpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt,
  input  logic             wr_scl,
  input  logic             wr_ctl,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [SCL_W-1:0] scl_wdata,
  input  logic [FLD_W-1:0] field,
  output logic [CNT_W-1:0] cnt_live,
  output logic [SCL_W-1:0] scl_live,
  output logic [CNT_W-1:0] cnt_prog,
  output logic             en_q,
  output logic             rld_q,
  output logic             ld_cnt,
  output logic             irq_q
);
  logic [CNT_W-1:0] cnt_prog_d;
  logic [SCL_W-1:0] scl_prog_q, scl_prog_d;
  logic             en_d, rld_d, irq_d;
  logic             ld_scl, wrap, underflow;

  assign ld_cnt = wr_ctl & field[BIT_LDCNT];
  assign ld_scl = wr_ctl & field[BIT_LDSCL];

  dpt_prescaler #(.SCL_W(SCL_W)) presc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (en_q),
    .load       (ld_scl),
    .reload_val (scl_prog_q),
    .presc_q    (scl_live),
    .wrap       (wrap)
  );

  dpt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (wrap),
    .load        (ld_cnt),
    .reload_mode (rld_q),
    .reload_val  (cnt_prog),
    .cnt_q       (cnt_live),
    .underflow   (underflow)
  );

  always_comb begin
    cnt_prog_d = wr_cnt ? cnt_wdata : cnt_prog;
    scl_prog_d = wr_scl ? scl_wdata : scl_prog_q;
    rld_d      = wr_ctl ? field[BIT_RELOAD] : rld_q;
    en_d       = en_q;
    if (wr_ctl)
      en_d = field[BIT_ENABLE];
    else if (underflow && !rld_q)
      en_d = 1'b0;
    irq_d = underflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_prog   <= '0;
      scl_prog_q <= '0;
      en_q       <= 1'b0;
      rld_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      cnt_prog   <= cnt_prog_d;
      scl_prog_q <= scl_prog_d;
      en_q       <= en_d;
      rld_q      <= rld_d;
      irq_q      <= irq_d;
    end
  end
endmodule

// File: rtl/dual_prescaled_timer.sv
module dual_prescaled_timer
  import dpt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int GPT_SCL_W = 16,
  parameter int RTC_SCL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_gpt,
  output logic              irq_rtc
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  logic ctl_wr;
  logic gpt_wr_cnt, gpt_wr_scl, rtc_wr_cnt, rtc_wr_scl;

  assign ctl_wr     = reg_wr & (reg_addr == ADDR_W'(OFS_CTRL));
  assign gpt_wr_cnt = reg_wr & (reg_addr == ADDR_W'(OFS_GPT_CNT));
  assign gpt_wr_scl = reg_wr & (reg_addr == ADDR_W'(OFS_GPT_SCL));
  assign rtc_wr_cnt = reg_wr & (reg_addr == ADDR_W'(OFS_RTC_CNT));
  assign rtc_wr_scl = reg_wr & (reg_addr == ADDR_W'(OFS_RTC_SCL));

  logic [CNT_W-1:0]     gpt_cnt, gpt_cnt_prog, rtc_cnt, rtc_cnt_prog;
  logic [GPT_SCL_W-1:0] gpt_presc;
  logic [RTC_SCL_W-1:0] rtc_presc;
  logic                 gpt_en, gpt_rld, gpt_ldc;
  logic                 rtc_en, rtc_rld, rtc_ldc;

  dpt_channel #(.CNT_W(CNT_W), .SCL_W(GPT_SCL_W)) gpt_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_cnt    (gpt_wr_cnt),
    .wr_scl    (gpt_wr_scl),
    .wr_ctl    (ctl_wr),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .scl_wdata (reg_wdata[GPT_SCL_W-1:0]),
    .field     (reg_wdata[GPT_FLD_LSB +: FLD_W]),
    .cnt_live  (gpt_cnt),
    .scl_live  (gpt_presc),
    .cnt_prog  (gpt_cnt_prog),
    .en_q      (gpt_en),
    .rld_q     (gpt_rld),
    .ld_cnt    (gpt_ldc),
    .irq_q     (irq_gpt)
  );

  dpt_channel #(.CNT_W(CNT_W), .SCL_W(RTC_SCL_W)) rtc_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_cnt    (rtc_wr_cnt),
    .wr_scl    (rtc_wr_scl),
    .wr_ctl    (ctl_wr),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .scl_wdata (reg_wdata[RTC_SCL_W-1:0]),
    .field     (reg_wdata[RTC_FLD_LSB +: FLD_W]),
    .cnt_live  (rtc_cnt),
    .scl_live  (rtc_presc),
    .cnt_prog  (rtc_cnt_prog),
    .en_q      (rtc_en),
    .rld_q     (rtc_rld),
    .ld_cnt    (rtc_ldc),
    .irq_q     (irq_rtc)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_RTC_CNT): reg_rdata[CNT_W-1:0]     = rtc_cnt;
      ADDR_W'(OFS_RTC_SCL): reg_rdata[RTC_SCL_W-1:0] = rtc_presc;
      ADDR_W'(OFS_GPT_CNT): reg_rdata[CNT_W-1:0]     = gpt_cnt;
      ADDR_W'(OFS_GPT_SCL): reg_rdata[GPT_SCL_W-1:0] = gpt_presc;
      ADDR_W'(OFS_CTRL): begin
        reg_rdata[GPT_FLD_LSB + BIT_RELOAD] = gpt_rld;
        reg_rdata[GPT_FLD_LSB + BIT_ENABLE] = gpt_en;
        reg_rdata[RTC_FLD_LSB + BIT_RELOAD] = rtc_rld;
        reg_rdata[RTC_FLD_LSB + BIT_ENABLE] = rtc_en;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
  parameter int CNT_W     = 32,
  parameter int GPT_SCL_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctl_wr,
  input logic                 gpt_ldc,
  input logic [CNT_W-1:0]     gpt_cnt,
  input logic [CNT_W-1:0]     gpt_cnt_prog,
  input logic [GPT_SCL_W-1:0] gpt_presc,
  input logic                 gpt_en,
  input logic                 gpt_rld,
  input logic                 irq_gpt,
  input logic [CNT_W-1:0]     rtc_cnt,
  input logic                 rtc_en,
  input logic                 irq_rtc
);
  // R5
  gpt_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gpt |-> ($past(gpt_en) && $past(gpt_cnt) == '0));

  // R4
  gpt_step_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpt_en && gpt_presc != '0 && !ctl_wr) |=> $stable(gpt_cnt));

  // R7
  gpt_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gpt_en && !ctl_wr) |=> $stable(gpt_cnt));

  // R8
  gpt_load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && gpt_ldc) |=> (gpt_cnt == $past(gpt_cnt_prog)));

  // R6
  gpt_stop_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_gpt && !$past(gpt_rld) && !$past(ctl_wr)) |-> !gpt_en);

  // R10
  rtc_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rtc |-> ($past(rtc_en) && $past(rtc_cnt) == '0));
endmodule

bind dual_prescaled_timer dpt_checker #(.CNT_W(CNT_W), .GPT_SCL_W(GPT_SCL_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr       (ctl_wr),
  .gpt_ldc      (gpt_ldc),
  .gpt_cnt      (gpt_cnt),
  .gpt_cnt_prog (gpt_cnt_prog),
  .gpt_presc    (gpt_presc),
  .gpt_en       (gpt_en),
  .gpt_rld      (gpt_rld),
  .irq_gpt      (irq_gpt),
  .rtc_cnt      (rtc_cnt),
  .rtc_en       (rtc_en),
  .irq_rtc      (irq_rtc)
);

// File: tb/dual_prescaled_timer_tb_top.sv
`timescale 1ns/1ps
module dual_prescaled_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_gpt;
  logic        irq_rtc;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_RTC_CNT = 8'h80;
  localparam logic [7:0] A_RTC_SCL = 8'h84;
  localparam logic [7:0] A_GPT_CNT = 8'h88;
  localparam logic [7:0] A_GPT_SCL = 8'h8C;
  localparam logic [7:0] A_CTRL    = 8'h98;

  dual_prescaled_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_gpt   (irq_gpt),
    .irq_rtc   (irq_rtc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(A_GPT_CNT, v); check("R1 gpt counter", v, 0);
    rd(A_RTC_SCL, v); check("R1 rtc scaler", v, 0);
    rd(A_CTRL, v);    check("R1 control", v, 0);
    check("R1 irqs", {30'd0, irq_rtc, irq_gpt}, 0);
  endtask

  task automatic t_prog_vs_live();
    logic [31:0] v;
    do_reset();
    wr(A_GPT_CNT, 32'd55);
    rd(A_GPT_CNT, v); check("R2 live unchanged by programmed write", v, 0);
    wr(A_CTRL, 32'h2);
    rd(A_GPT_CNT, v); check("R2 load strobe copies value", v, 55);
    rd(A_CTRL, v);    check("R2 strobe not persistent", v, 0);
    rd(8'h90, v);     check("R3 unmapped reads zero", v, 0);
  endtask

  task automatic t_reload_run();
    logic [31:0] v;
    do_reset();
    wr(A_GPT_CNT, 32'd3);
    wr(A_GPT_SCL, 32'd0);
    wr(A_CTRL, 32'hF);
    rd(A_GPT_CNT, v); check("R5 start", v, 3);
    step(1); rd(A_GPT_CNT, v); check("R4 S=0 step", v, 2);
    step(1); rd(A_GPT_CNT, v); check("R4 S=0 step", v, 1);
    step(1); rd(A_GPT_CNT, v); check("R4 at zero", v, 0);
    check("R5 no pulse before underflow", {31'd0, irq_gpt}, 0);
    step(1); rd(A_GPT_CNT, v); check("R5 reload after underflow", v, 3);
    check("R5 pulse", {31'd0, irq_gpt}, 1);
    step(1); rd(A_GPT_CNT, v); check("R5 keeps running", v, 2);
    check("R5 pulse lasts one cycle", {31'd0, irq_gpt}, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    do_reset();
    wr(A_GPT_CNT, 32'd2);
    wr(A_GPT_SCL, 32'd4);
    wr(A_CTRL, 32'hF);
    step(4);
    rd(A_GPT_CNT, v); check("R4 counter held during prescale", v, 2);
    rd(A_GPT_SCL, v); check("R4 prescaler at zero", v, 0);
    step(1);
    rd(A_GPT_CNT, v); check("R4 counter steps on wrap", v, 1);
    rd(A_GPT_SCL, v); check("R4 prescaler reloaded", v, 4);
    step(5);
    rd(A_GPT_CNT, v); check("R4 second step", v, 0);
    step(4);
    check("R5 no early pulse", {31'd0, irq_gpt}, 0);
    step(1);
    check("R5 pulse after S+1 cycles at zero", {31'd0, irq_gpt}, 1);
    rd(A_GPT_CNT, v); check("R5 reload", v, 2);
  endtask

  task automatic t_stop_mode();
    logic [31:0] v;
    int pulses;
    do_reset();
    wr(A_GPT_CNT, 32'd2);
    wr(A_GPT_SCL, 32'd0);
    wr(A_CTRL, 32'hE);
    rd(A_CTRL, v); check("R3 enable readback bit 2 only", v, 32'h4);
    step(2);
    rd(A_GPT_CNT, v); check("R6 at zero", v, 0);
    step(1);
    check("R6 pulse in stop mode", {31'd0, irq_gpt}, 1);
    rd(A_CTRL, v); check("R6 enable cleared", v, 0);
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (irq_gpt) pulses++;
    end
    check("R6 no further pulses", pulses, 0);
    rd(A_GPT_CNT, v); check("R6 counter stays zero", v, 0);
  endtask

  task automatic t_load_wins_and_hold();
    logic [31:0] v, held, hs;
    do_reset();
    wr(A_GPT_CNT, 32'd10);
    wr(A_GPT_SCL, 32'd0);
    wr(A_CTRL, 32'hF);
    step(3);
    rd(A_GPT_CNT, v); check("R4 running", v, 7);
    wr(A_CTRL, 32'h7);
    rd(A_GPT_CNT, v); check("R8 load beats decrement", v, 10);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v); check("R7 enable off, mode kept", v, 32'h1);
    rd(A_GPT_CNT, held);
    rd(A_GPT_SCL, hs);
    step(5);
    rd(A_GPT_CNT, v); check("R7 counter holds while disabled", v, held);
    rd(A_GPT_SCL, v); check("R7 prescaler holds while disabled", v, hs);
    check("R7 no pulse while disabled", {31'd0, irq_gpt}, 0);
  endtask

  task automatic t_scaler_width();
    logic [31:0] v;
    do_reset();
    wr(A_RTC_SCL, 32'hFFFF);
    wr(A_GPT_SCL, 32'h12345);
    rd(A_RTC_SCL, v); check("R2 scaler not live before strobe", v, 0);
    wr(A_CTRL, 32'h808);
    rd(A_RTC_SCL, v); check("R9 rtc scaler 10 bits", v, 32'h3FF);
    rd(A_GPT_SCL, v); check("R9 gpt scaler 16 bits", v, 32'h2345);
    wr(A_GPT_CNT, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h2);
    rd(A_GPT_CNT, v); check("R9 counter 32 bits", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_rtc_indep();
    logic [31:0] v;
    do_reset();
    wr(A_RTC_CNT, 32'd1);
    wr(A_RTC_SCL, 32'd0);
    wr(A_CTRL, 32'hF00);
    rd(A_RTC_CNT, v); check("R10 rtc loaded from bits 11:8", v, 1);
    rd(A_GPT_CNT, v); check("R10 gpt untouched", v, 0);
    rd(A_CTRL, v);    check("R3 rtc mode bits readback", v, 32'h500);
    step(1);
    rd(A_RTC_CNT, v); check("R10 rtc at zero", v, 0);
    step(1);
    check("R10 rtc pulse", {31'd0, irq_rtc}, 1);
    check("R10 gpt quiet", {31'd0, irq_gpt}, 0);
    rd(A_RTC_CNT, v); check("R10 rtc reload", v, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    step(1);
    t_reset();
    t_prog_vs_live();
    t_reload_run();
    t_prescale();
    t_stop_mode();
    t_load_wins_and_hold();
    t_scaler_width();
    t_rtc_indep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule